// File: doc/BRIEF.md
# Toggle-Based Reloadable PWM Timer

This block is one channel of a 24-bit up-counting timer set up to produce a pulse-width-modulated waveform on a single output pin. The output is not built from a threshold comparison. It flips level whenever the counter reaches the compare value, and it flips again whenever the counter rolls past its all-ones value. Once enabled, the output starts from a programmable initial level. In reload mode, the counter restarts from a load value on every rollover. The period in ticks is therefore (all-ones − load + 1), and the compare value sets where the level changes inside that period. For example, with a load of 0xFFFFF0 a compare of 0xFFFFF8 gives an even 50% split. Correct waveforms need the compare value to be above the load value.

The counter moves only on cycles where the single-cycle `tick` input is high, so a shared prescaler can set the count rate. A small register port sets up the channel. It holds a control/status word, the load value, the compare value and a read-only capture register. Each compare match copies the counter into the capture register. A compare flag and an overflow flag record the events. Each flag drives an interrupt line through its own enable bit, and software clears a flag by writing a one to it.

Top module: `pwm_toggle_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared: all four addresses read zero, `pwm_out` is 0 and both interrupt lines are 0.
- R2: Register addresses: 0 = control/status, 1 = load value, 2 = compare value, 3 = capture (read-only). Control/status bits: bit 0 enable, bit 1 initial level, bit 2 reload mode, bit 3 compare interrupt enable, bit 4 overflow interrupt enable, bits 11:8 mode, bit 16 compare flag, bit 17 overflow flag. Writes to addresses 1 and 2 read back unchanged.
- R3: The channel runs only while enable is 1 and mode is 4'b0111. On the first clock after it becomes running, the counter takes the load value and `pwm_out` takes the initial-level bit. A `tick` in that cycle is not counted.
- R4: The counter advances by one only in cycles where `tick` is high. Cycles without `tick` change neither the counter nor `pwm_out`.
- R5: When a tick moves the counter onto the compare value, `pwm_out` toggles, the compare flag sets and the capture register takes that counter value.
- R6: A tick while the counter holds all-ones toggles `pwm_out` and sets the overflow flag.
- R7: In reload mode, the overflow tick loads the counter with the load value, so the output repeats every (0xFFFFFF − load + 1) ticks.
- R8: With reload mode clear, the overflow tick wraps the counter to zero and counting continues from there.
- R9: While not running, ticks are ignored and `pwm_out` holds its level. Running again restarts from the load value with the initial level reapplied.
- R10: Writing 1 to a flag bit at address 0 clears that flag. If a flag's set event falls in the same cycle as its clearing write, the flag stays set.
- R11: `cmp_irq` equals the compare flag ANDed with bit 3, and `ovf_irq` equals the overflow flag ANDed with bit 4.
- R12: With enable set but mode not 4'b0111, ticks leave `pwm_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 24 | Read data (combinational) |
| pwm_out | output | 1 | Waveform output |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two events can land on the same clock edge: a compare match that sets the compare flag, and a software write that clears that same flag. The bench first counts the channel up to one step below the compare value. It then drives a tick together with a write-one-to-clear in the same cycle, and reads back the status word. The flag must still read set, and the output must have toggled, since that match happened.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int unsigned CNT_W = 24;

    // register addresses
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_LOAD = 2'd1;
    localparam logic [1:0] ADR_CMP  = 2'd2;
    localparam logic [1:0] ADR_CAP  = 2'd3;

    // control/status bit positions
    localparam int unsigned B_EN   = 0;
    localparam int unsigned B_INV  = 1;
    localparam int unsigned B_RLD  = 2;
    localparam int unsigned B_CIE  = 3;
    localparam int unsigned B_OIE  = 4;
    localparam int unsigned B_MODE = 8;
    localparam int unsigned B_CF   = 16;
    localparam int unsigned B_OF   = 17;

    localparam logic [3:0] MODE_PWM = 4'b0111;

    typedef struct packed {
        logic [3:0] mode;
        logic       oie;
        logic       cie;
        logic       rld;
        logic       inv;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic cmp;
        logic ovf;
    } evt_t;

    function automatic ctrl_t decode_ctrl(input logic [CNT_W-1:0] w);
        ctrl_t c;
        c.mode = w[B_MODE +: 4];
        c.oie  = w[B_OIE];
        c.cie  = w[B_CIE];
        c.rld  = w[B_RLD];
        c.inv  = w[B_INV];
        c.en   = w[B_EN];
        return c;
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    input  evt_t          evt,
    input  logic [CW-1:0] cap_val,
    output ctrl_t         ctrl,
    output logic [CW-1:0] load_val,
    output logic [CW-1:0] cmp_val,
    output logic [CW-1:0] capture,
    output logic          cmp_flag,
    output logic          ovf_flag,
    output logic [CW-1:0] rd_data
);

    logic wr_ctrl;
    logic clr_cf, clr_of;

    assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
    assign clr_cf  = wr_ctrl && wr_data[B_CF];
    assign clr_of  = wr_ctrl && wr_data[B_OF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            load_val <= '0;
            cmp_val  <= '0;
            capture  <= '0;
            cmp_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_ctrl)                          ctrl     <= decode_ctrl(wr_data);
            if (wr_en && wr_addr == ADR_LOAD)     load_val <= wr_data;
            if (wr_en && wr_addr == ADR_CMP)      cmp_val  <= wr_data;
            if (evt.cmp)                          capture  <= cap_val;
            // a set event outranks a same-cycle clear
            cmp_flag <= evt.cmp || (cmp_flag && !clr_cf);
            ovf_flag <= evt.ovf || (ovf_flag && !clr_of);
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[B_EN]        = ctrl.en;
                rd_data[B_INV]       = ctrl.inv;
                rd_data[B_RLD]       = ctrl.rld;
                rd_data[B_CIE]       = ctrl.cie;
                rd_data[B_OIE]       = ctrl.oie;
                rd_data[B_MODE +: 4] = ctrl.mode;
                rd_data[B_CF]        = cmp_flag;
                rd_data[B_OF]        = ovf_flag;
            end
            ADR_LOAD: rd_data = load_val;
            ADR_CMP:  rd_data = cmp_val;
            default:  rd_data = capture;
        endcase
    end

    p_set_wins_cmp_r10: assert property (@(posedge clk) disable iff (rst)
        evt.cmp |=> cmp_flag);
    p_set_wins_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> ovf_flag);
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr_cf && !evt.cmp) |=> !cmp_flag);

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic [3:0]    mode,
    input  logic          inv,
    input  logic          rld,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] cmp_val,
    output evt_t          evt,
    output logic [CW-1:0] cap_val,
    output logic          pwm_out
);

    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic          run, run_q, start, adv, at_top;
    logic [CW-1:0] cnt, nxt;

    assign run    = en && (mode == MODE_PWM);
    assign start  = run && !run_q;
    assign adv    = run && !start && tick;
    assign at_top = (cnt == TOP);
    assign nxt    = at_top ? (rld ? load_val : '0) : cnt + CW'(1);

    assign evt.ovf = adv && at_top;
    assign evt.cmp = adv && (nxt == cmp_val);
    assign cap_val = nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            cnt     <= '0;
            pwm_out <= 1'b0;
        end else begin
            run_q <= run;
            if (start) begin
                cnt     <= load_val;
                pwm_out <= inv;
            end else if (adv) begin
                cnt     <= nxt;
                pwm_out <= pwm_out ^ (evt.cmp ^ evt.ovf);
            end
        end
    end

    p_start_level_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (pwm_out == $past(inv)));
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q && run && !tick) |=> $stable(pwm_out));
    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(pwm_out));
    p_toggle_cmp_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.cmp && !evt.ovf) |=> (pwm_out != $past(pwm_out)));
    p_toggle_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        (evt.ovf && !evt.cmp) |=> (pwm_out != $past(pwm_out)));

endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer
    import pwmt_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          pwm_out,
    output logic          cmp_irq,
    output logic          ovf_irq
);

    ctrl_t         ctrl;
    evt_t          evt;
    logic [CW-1:0] load_val, cmp_val, capture, cap_val;
    logic          cmp_flag, ovf_flag;

    pwmt_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .evt      (evt),
        .cap_val  (cap_val),
        .ctrl     (ctrl),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .capture  (capture),
        .cmp_flag (cmp_flag),
        .ovf_flag (ovf_flag),
        .rd_data  (rd_data)
    );

    pwmt_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (ctrl.en),
        .mode     (ctrl.mode),
        .inv      (ctrl.inv),
        .rld      (ctrl.rld),
        .load_val (load_val),
        .cmp_val  (cmp_val),
        .evt      (evt),
        .cap_val  (cap_val),
        .pwm_out  (pwm_out)
    );

    assign cmp_irq = cmp_flag && ctrl.cie;
    assign ovf_irq = ovf_flag && ctrl.oie;

    p_cap_match_r5: assert property (@(posedge clk) disable iff (rst)
        evt.cmp |=> (capture == $past(cmp_val)));
    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (rst)
        evt.cmp && ctrl.cie |=> cmp_irq);

endmodule

// File: tb/test_pwm_toggle_timer.sv
module test_pwm_toggle_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [23:0] wr_data = 24'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [23:0] rd_data;
    logic        pwm_out, cmp_irq, ovf_irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [23:0] LD  = 24'hFFFFF0;
    localparam logic [23:0] CP  = 24'hFFFFF8;
    localparam logic [23:0] CP2 = 24'hFFFFF4;

    // {ticks to apply, expected pwm_out afterwards}, initial level 1, reload mode
    localparam logic [8:0] STEP_TBL [0:6] = '{
        {8'd0, 1'b1}, {8'd7, 1'b1}, {8'd1, 1'b0}, {8'd7, 1'b0},
        {8'd1, 1'b1}, {8'd8, 1'b0}, {8'd8, 1'b1}
    };

    pwm_toggle_timer i_pwm_toggle_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] cw(input bit en, input bit inv, input bit rld,
                                       input bit cie, input bit oie, input logic [3:0] mode);
        logic [23:0] w;
        w = '0;
        w[0] = en; w[1] = inv; w[2] = rld; w[3] = cie; w[4] = oie;
        w[11:8] = mode;
        return w;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk); // idle cycle between ticks exercises R4
        end
    endtask

    logic [23:0] v;
    logic [23:0] run_w;
    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pwm_out", {23'd0, pwm_out}, 24'd0);
        check("R1 irqs", {22'd0, cmp_irq, ovf_irq}, 24'd0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register zero", v, 24'd0);
        end

        // R2 setup and readback
        wr(2'd1, LD);
        wr(2'd2, CP);
        rd(2'd1, v); check("R2 load readback", v, LD);
        rd(2'd2, v); check("R2 compare readback", v, CP);

        // R12 wrong mode: enabled with mode 0, no start, no counting
        wr(2'd0, cw(1, 1, 1, 1, 0, 4'b0000));
        @(negedge clk);
        ticks(10);
        check("R12 pwm_out held", {23'd0, pwm_out}, 24'd0);
        rd(2'd0, v); check("R12 no compare flag", v[16], 1'b0);

        // R3 start in pwm mode, reload, cmp irq on
        run_w = cw(1, 1, 1, 1, 0, 4'b0111);
        wr(2'd0, run_w);
        @(negedge clk);

        // R5/R6/R7 table walk
        for (int s = 0; s < 7; s++) begin
            ticks(int'(STEP_TBL[s][8:1]));
            check(s == 0 ? "R3 initial level" : "R7 waveform step",
                  {23'd0, pwm_out}, {23'd0, STEP_TBL[s][0]});
        end
        rd(2'd3, v); check("R5 capture", v, CP);
        rd(2'd0, v); check("R5 compare flag", v[16], 1'b1);
        check("R6 overflow flag", v[17], 1'b1);
        check("R11 cmp_irq on", {23'd0, cmp_irq}, 24'd1);
        check("R11 ovf_irq gated", {23'd0, ovf_irq}, 24'd0);

        // R10 write-one-to-clear
        wr(2'd0, run_w | 24'h030000);
        rd(2'd0, v);
        check("R10 flags cleared", {22'd0, v[17:16]}, 24'd0);
        check("R11 cmp_irq off", {23'd0, cmp_irq}, 24'd0);

        // R10 set wins: clear write on the same cycle as a compare match
        ticks(7);
        check("R10 pre-match level", {23'd0, pwm_out}, 24'd1);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = run_w | 24'h010000;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(2'd0, v); check("R10 set wins", v[16], 1'b1);
        check("R5 toggled on match", {23'd0, pwm_out}, 24'd0);

        // R9 disable freezes output
        wr(2'd0, cw(0, 1, 1, 1, 0, 4'b0111));
        ticks(20);
        check("R9 frozen", {23'd0, pwm_out}, 24'd0);
        wr(2'd2, CP2);
        wr(2'd0, run_w | 24'h030000); // clear both flags
        // re-enable: free-run mode, level 1
        run_w = cw(1, 1, 0, 1, 0, 4'b0111);
        wr(2'd0, 24'd0);
        wr(2'd0, run_w);
        @(negedge clk);
        check("R9 level reapplied", {23'd0, pwm_out}, 24'd1);
        ticks(4);
        check("R9 restarted from load", {23'd0, pwm_out}, 24'd0);
        ticks(12);
        check("R6 overflow toggle", {23'd0, pwm_out}, 24'd1);
        ticks(20);
        check("R8 wrapped to zero", {23'd0, pwm_out}, 24'd1);
        rd(2'd0, v); check("R8 overflow flag", v[17], 1'b1);
        wr(2'd0, run_w | 24'h000010);
        check("R11 ovf_irq on", {23'd0, ovf_irq}, 24'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule